// File: doc/BRIEF.md
# Memory Ordering Issue Gate

This block sits between the memory-operation tracker of a core and the port that sends operations to memory. It keeps a small circular window of pending operations in program order. Each entry is a read, a write or a barrier, and each read or write carries an address. That address may be supplied later through a resolve port. Every cycle the gate works out which entries may legally go to memory under the ordering policy chosen on `mode`. It offers the oldest such entry on a valid/ready issue port and shows the single permitted entry as a one-hot vector.

The four policies are strict sequential order, a store-ordered policy in which reads may pass older writes, a partial store policy in which reads and writes may pass older writes, and a weak policy in which only writes constrain later operations. In every policy an operation may pass an older write only when both addresses are known and differ. A barrier serialises the window in every policy. Completion pulses name an entry by index. Completed entries leave from the head in order, one per cycle.

Back-pressure: a new operation is accepted only in a cycle where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` is low while all slots are occupied. The entry is written to slot `alloc_idx`. An issue transfer happens in a cycle where `issue_valid` and `issue_ready` are both high. Because the offer is a permission and not a committed transfer, `issue_valid` and `issue_idx` may change or fall while `issue_ready` is low. This happens when completions or address updates make an older entry eligible. `mode` is expected to change only while the window is empty.

Top module: `mem_order_gate`

## Requirements
- R1: After reset the window is empty, `alloc_ready` is 1, `issue_valid` is 0 and `issue_permit` is all zero.
- R2: `alloc_kind` is encoded 00 read, 01 write, 10 barrier (11 behaves as a barrier). An operation is stored at slot `alloc_idx` when `alloc_valid` and `alloc_ready` are both high. Slots are used in ascending order with wrap-around. `alloc_ready` is 0 exactly when 8 entries are held.
- R3: With `mode` = 00 (sequential), an entry is permitted only when every older entry has completed.
- R4: With `mode` = 01 (store-ordered), an older incomplete read blocks all younger entries. An older incomplete write blocks younger writes. A younger read may pass an older incomplete write.
- R5: With `mode` = 10 (partial store), an older incomplete read blocks all younger entries. Younger reads and writes may pass older incomplete writes.
- R6: With `mode` = 11 (weak), older reads never block. Younger entries may pass older incomplete writes.
- R7: Passing an older incomplete write requires both addresses known and unequal. An older incomplete entry with an unknown address blocks every younger entry. A read or write whose own address is unknown is never permitted.
- R8: A barrier is permitted only when every older entry has completed. While a barrier is incomplete, no younger entry is permitted, in every mode.
- R9: `issue_permit` is one-hot or zero and marks the oldest eligible entry. `issue_idx`, `issue_kind` and `issue_addr` describe that entry. A granted entry is never offered again.
- R10: A `cmpl_valid` pulse marks entry `cmpl_idx` complete only if that entry is held and already issued; otherwise it has no effect.
- R11: A completed entry at the head leaves the window on the next clock edge, one entry per cycle, and frees its slot.
- R12: A `rslv_valid` pulse sets the address of held read/write entry `rslv_idx` if that address is still unknown; otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Ordering policy: 00 sequential, 01 store-ordered, 10 partial store, 11 weak |
| alloc_valid | input | 1 | New operation offered |
| alloc_ready | output | 1 | Window has a free slot |
| alloc_kind | input | 2 | Operation kind: 00 read, 01 write, 10 barrier |
| alloc_addr | input | 16 | Operation address |
| alloc_addr_known | input | 1 | The address is valid at allocation |
| alloc_idx | output | 3 | Slot that the next accepted operation takes |
| rslv_valid | input | 1 | Address update pulse |
| rslv_idx | input | 3 | Slot to update |
| rslv_addr | input | 16 | Resolved address |
| issue_permit | output | 8 | One-hot permission per slot |
| issue_valid | output | 1 | An entry is offered for issue |
| issue_ready | input | 1 | Memory accepts the offered entry |
| issue_idx | output | 3 | Slot of the offered entry |
| issue_kind | output | 2 | Kind of the offered entry |
| issue_addr | output | 16 | Address of the offered entry |
| cmpl_valid | input | 1 | Completion pulse |
| cmpl_idx | input | 3 | Slot that completed |

## Verification
Several events can land on the same clock edge: an issue grant, a completion pulse for a different in-flight entry, an allocation at the tail, an address update and the retirement of the head. The most telling pair is a grant together with a completion that unblocks a younger entry. The grant must take the entry offered before the edge. The completion may only change the offer in the following cycle. Random traffic drives all these inputs independently, with the issue port often ready while completions arrive. A behavioural model in the bench predicts, for every cycle, the one-hot permit, the offered slot and the allocation state, and compares them to the outputs.

// File: rtl/ogate_pkg.sv
package ogate_pkg;

  typedef enum logic [1:0] {
    MD_SEQ  = 2'b00,
    MD_TSO  = 2'b01,
    MD_PSO  = 2'b10,
    MD_WEAK = 2'b11
  } order_mode_e;

  localparam logic [1:0] KIND_READ    = 2'b00;
  localparam logic [1:0] KIND_WRITE   = 2'b01;
  localparam logic [1:0] KIND_BARRIER = 2'b10;

  // Decide whether an older incomplete entry holds back a younger one.
  function automatic logic must_wait(
    input order_mode_e m,
    input logic        y_bar,
    input logic        y_wr,
    input logic        o_bar,
    input logic        o_wr,
    input logic        o_known,
    input logic        same_addr
  );
    logic w;
    if (y_bar || o_bar)      w = 1'b1;
    else if (!o_known)       w = 1'b1;
    else begin
      unique case (m)
        MD_SEQ:  w = 1'b1;
        MD_TSO:  w = !o_wr ? 1'b1 : (y_wr ? 1'b1 : same_addr);
        MD_PSO:  w = !o_wr ? 1'b1 : same_addr;
        default: w = o_wr ? same_addr : 1'b0;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/ogate_window.sv
module ogate_window #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [1:0]        alloc_kind,
  input  logic [AW-1:0]     alloc_addr,
  input  logic              alloc_known,
  output logic [IW-1:0]     alloc_idx,
  input  logic              grant_valid,
  input  logic [IW-1:0]     grant_idx,
  input  logic              cmpl_valid,
  input  logic [IW-1:0]     cmpl_idx,
  input  logic              rslv_valid,
  input  logic [IW-1:0]     rslv_idx,
  input  logic [AW-1:0]     rslv_addr,
  output logic [DEPTH-1:0]  vld_o,
  output logic [DEPTH-1:0]  iss_o,
  output logic [DEPTH-1:0]  dne_o,
  output logic [DEPTH-1:0]  knw_o,
  output logic [DEPTH-1:0]  bar_o,
  output logic [DEPTH-1:0]  wr_o,
  output logic [AW-1:0]     addr_o [DEPTH],
  output logic [IW-1:0]     head_o
);

  logic [DEPTH-1:0] vld, iss, dne, knw, bar, wr;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [IW-1:0]    head, tail;
  logic [IW:0]      occ;

  logic alloc_fire, retire, cmpl_hit, rslv_hit;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign alloc_ready = (occ != (IW + 1)'(DEPTH));
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail;
  assign retire      = vld[head] && dne[head];
  assign cmpl_hit    = cmpl_valid && vld[cmpl_idx] && iss[cmpl_idx];
  assign rslv_hit    = rslv_valid && vld[rslv_idx] && !knw[rslv_idx] && !bar[rslv_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      iss  <= '0;
      dne  <= '0;
      knw  <= '0;
      bar  <= '0;
      wr   <= '0;
      head <= '0;
      tail <= '0;
      occ  <= '0;
      for (int k = 0; k < DEPTH; k++) addr_q[k] <= '0;
    end else begin
      if (retire) begin
        vld[head] <= 1'b0;
        head      <= step(head);
      end
      if (alloc_fire) begin
        vld[tail]    <= 1'b1;
        iss[tail]    <= 1'b0;
        dne[tail]    <= 1'b0;
        bar[tail]    <= alloc_kind[1];
        wr[tail]     <= (alloc_kind == ogate_pkg::KIND_WRITE);
        knw[tail]    <= alloc_known | alloc_kind[1];
        addr_q[tail] <= alloc_addr;
        tail         <= step(tail);
      end
      if (grant_valid) iss[grant_idx] <= 1'b1;
      if (cmpl_hit)    dne[cmpl_idx]  <= 1'b1;
      if (rslv_hit) begin
        knw[rslv_idx]    <= 1'b1;
        addr_q[rslv_idx] <= rslv_addr;
      end
      case ({alloc_fire, retire})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign vld_o  = vld;
  assign iss_o  = iss;
  assign dne_o  = dne;
  assign knw_o  = knw;
  assign bar_o  = bar;
  assign wr_o   = wr;
  assign addr_o = addr_q;
  assign head_o = head;

  // R2: an accepted operation grows the window when nothing retires
  assert_alloc_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !retire) |=> (occ == $past(occ) + 1'b1));

  // R11: a retiring head shrinks the window and advances the head
  assert_retire_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !alloc_fire) |=> (occ == $past(occ) - 1'b1) && (head != $past(head) || DEPTH == 1));

endmodule

// File: rtl/ogate_hazard.sv
module ogate_hazard #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  ogate_pkg::order_mode_e mode,
  input  logic [IW-1:0]          head,
  input  logic [DEPTH-1:0]       vld,
  input  logic [DEPTH-1:0]       iss,
  input  logic [DEPTH-1:0]       dne,
  input  logic [DEPTH-1:0]       knw,
  input  logic [DEPTH-1:0]       bar,
  input  logic [DEPTH-1:0]       wr,
  input  logic [AW-1:0]          addr [DEPTH],
  output logic [DEPTH-1:0]       elig
);

  function automatic int age_of(input int idx, input int hd);
    return (idx + DEPTH - hd) % DEPTH;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic blk_i;
    always_comb begin
      blk_i = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && vld[j] && !dne[j] && age_of(j, int'(head)) < age_of(i, int'(head)))
          blk_i = blk_i | ogate_pkg::must_wait(mode, bar[i], wr[i], bar[j], wr[j], knw[j],
                                               addr[i] == addr[j]);
      end
    end
    assign elig[i] = vld[i] & ~iss[i] & (bar[i] | knw[i]) & ~blk_i;
  end

endmodule

// File: rtl/ogate_pick.sv
module ogate_pick #(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [IW-1:0]    head,
  input  logic [DEPTH-1:0] elig,
  output logic [DEPTH-1:0] permit,
  output logic [IW-1:0]    idx,
  output logic             any
);

  always_comb begin
    any    = 1'b0;
    idx    = '0;
    permit = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int s;
      s = (int'(head) + k) % DEPTH;
      if (!any && elig[s]) begin
        any = 1'b1;
        idx = IW'(s);
      end
    end
    if (any) permit[idx] = 1'b1;
  end

endmodule

// File: rtl/mem_order_gate.sv
module mem_order_gate #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [1:0]        alloc_kind,
  input  logic [AW-1:0]     alloc_addr,
  input  logic              alloc_addr_known,
  output logic [IW-1:0]     alloc_idx,
  input  logic              rslv_valid,
  input  logic [IW-1:0]     rslv_idx,
  input  logic [AW-1:0]     rslv_addr,
  output logic [DEPTH-1:0]  issue_permit,
  output logic              issue_valid,
  input  logic              issue_ready,
  output logic [IW-1:0]     issue_idx,
  output logic [1:0]        issue_kind,
  output logic [AW-1:0]     issue_addr,
  input  logic              cmpl_valid,
  input  logic [IW-1:0]     cmpl_idx
);

  import ogate_pkg::*;

  logic [DEPTH-1:0] vld, iss, dne, knw, bar, wr, elig;
  logic [AW-1:0]    addr [DEPTH];
  logic [IW-1:0]    head;
  order_mode_e      mode_e;
  logic             grant;

  assign mode_e = order_mode_e'(mode);
  assign grant  = issue_valid && issue_ready;

  ogate_window #(.DEPTH(DEPTH), .AW(AW)) u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_ready (alloc_ready),
    .alloc_kind  (alloc_kind),
    .alloc_addr  (alloc_addr),
    .alloc_known (alloc_addr_known),
    .alloc_idx   (alloc_idx),
    .grant_valid (grant),
    .grant_idx   (issue_idx),
    .cmpl_valid  (cmpl_valid),
    .cmpl_idx    (cmpl_idx),
    .rslv_valid  (rslv_valid),
    .rslv_idx    (rslv_idx),
    .rslv_addr   (rslv_addr),
    .vld_o       (vld),
    .iss_o       (iss),
    .dne_o       (dne),
    .knw_o       (knw),
    .bar_o       (bar),
    .wr_o        (wr),
    .addr_o      (addr),
    .head_o      (head)
  );

  ogate_hazard #(.DEPTH(DEPTH), .AW(AW)) u_hazard (
    .mode (mode_e),
    .head (head),
    .vld  (vld),
    .iss  (iss),
    .dne  (dne),
    .knw  (knw),
    .bar  (bar),
    .wr   (wr),
    .addr (addr),
    .elig (elig)
  );

  ogate_pick #(.DEPTH(DEPTH)) u_pick (
    .head   (head),
    .elig   (elig),
    .permit (issue_permit),
    .idx    (issue_idx),
    .any    (issue_valid)
  );

  assign issue_kind = {bar[issue_idx], wr[issue_idx]};
  assign issue_addr = addr[issue_idx];

  // R9: a granted entry is not offered again on the following cycle
  assert_grant_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !issue_permit[$past(issue_idx)]);

  // R3: in sequential mode nothing is in flight when an entry is offered
  assert_seq_serial_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == MD_SEQ && issue_valid) |-> ((vld & iss & ~dne) == '0));

  // R7: an offered read or write always has a known address
  assert_issue_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !bar[issue_idx]) |-> knw[issue_idx]);

endmodule

// File: tb/mem_order_gate_tb.sv
module mem_order_gate_tb;

  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        alloc_valid = 1'b0;
  logic        alloc_ready;
  logic [1:0]  alloc_kind = 2'b00;
  logic [15:0] alloc_addr = '0;
  logic        alloc_addr_known = 1'b0;
  logic [2:0]  alloc_idx;
  logic        rslv_valid = 1'b0;
  logic [2:0]  rslv_idx = '0;
  logic [15:0] rslv_addr = '0;
  logic [7:0]  issue_permit;
  logic        issue_valid;
  logic        issue_ready = 1'b0;
  logic [2:0]  issue_idx;
  logic [1:0]  issue_kind;
  logic [15:0] issue_addr;
  logic        cmpl_valid = 1'b0;
  logic [2:0]  cmpl_idx = '0;

  always #10 clk = ~clk;

  mem_order_gate u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_kind(alloc_kind),
    .alloc_addr(alloc_addr), .alloc_addr_known(alloc_addr_known), .alloc_idx(alloc_idx),
    .rslv_valid(rslv_valid), .rslv_idx(rslv_idx), .rslv_addr(rslv_addr),
    .issue_permit(issue_permit), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_idx(issue_idx), .issue_kind(issue_kind), .issue_addr(issue_addr),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  string phase = "R1";

  // behavioural model: slot contents plus head/tail/count
  int  m_kind [D];
  int  m_addr [D];
  bit  m_v [D], m_i [D], m_d [D], m_k [D];
  int  m_head = 0, m_tail = 0, m_occ = 0, m_mode = 0;

  // next-cycle stimulus
  int n_mode = 0, n_ak = 0, n_aa = 0, n_ri = 0, n_ra = 0, n_ci = 0;
  bit n_av = 0, n_kn = 0, n_rv = 0, n_rdy = 0, n_cv = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic bit holds_back(input int o, input int y);
    bit same;
    if (m_kind[y] >= 2 || m_kind[o] >= 2) return 1;
    if (!m_k[o]) return 1;
    same = (m_addr[o] == m_addr[y]);
    case (m_mode)
      0: return 1;
      1: return (m_kind[o] == 0) || (m_kind[y] == 1) || same;
      2: return (m_kind[o] == 0) || same;
      default: return (m_kind[o] == 1) && same;
    endcase
  endfunction

  function automatic bit may_go(input int s);
    int age;
    if (!m_v[s] || m_i[s]) return 0;
    if (m_kind[s] < 2 && !m_k[s]) return 0;
    age = (s - m_head + D) % D;
    for (int t = 0; t < age; t++) begin
      int o;
      o = (m_head + t) % D;
      if (m_v[o] && !m_d[o] && holds_back(o, s)) return 0;
    end
    return 1;
  endfunction

  task automatic expect_issue(output bit any, output int idx);
    any = 0; idx = 0;
    for (int k = 0; k < D; k++) begin
      int s;
      s = (m_head + k) % D;
      if (!any && may_go(s)) begin any = 1; idx = s; end
    end
  endtask

  task automatic compare_now();
    bit any; int idx; int expp;
    m_mode = int'(mode);
    expect_issue(any, idx);
    expp = any ? (1 << idx) : 0;
    chk(alloc_ready == (m_occ < D), {phase, "/R2 alloc_ready"}, "ready", int'(alloc_ready), int'(m_occ < D));
    if (m_occ < D)
      chk(int'(alloc_idx) == m_tail, {phase, "/R2 alloc_idx"}, "slot", int'(alloc_idx), m_tail);
    chk(int'(issue_permit) == expp, {phase, "/", mode_tag(m_mode), "/R9 permit"}, "vector",
        int'(issue_permit), expp);
    chk(issue_valid == any, {phase, "/R9 issue_valid"}, "valid", int'(issue_valid), int'(any));
    if (any) begin
      chk(int'(issue_idx) == idx, {phase, "/R9 issue_idx"}, "idx", int'(issue_idx), idx);
      chk(int'(issue_kind) == (m_kind[idx] >= 2 ? 2 : m_kind[idx]), {phase, "/R9 issue_kind"}, "kind",
          int'(issue_kind), m_kind[idx]);
      if (m_kind[idx] < 2)
        chk(int'(issue_addr) == m_addr[idx], {phase, "/R12 issue_addr"}, "addr", int'(issue_addr), m_addr[idx]);
    end
  endtask

  task automatic model_step();
    bit any; int g; bit ret; bit chit; bit rhit; bit afire;
    expect_issue(any, g);
    ret   = m_v[m_head] && m_d[m_head];
    chit  = cmpl_valid && m_v[cmpl_idx] && m_i[cmpl_idx];
    rhit  = rslv_valid && m_v[rslv_idx] && !m_k[rslv_idx] && m_kind[rslv_idx] < 2;
    afire = alloc_valid && (m_occ < D);
    if (chit) m_d[cmpl_idx] = 1;
    if (any && issue_ready) m_i[g] = 1;
    if (rhit) begin m_k[rslv_idx] = 1; m_addr[rslv_idx] = int'(rslv_addr); end
    if (ret) begin m_v[m_head] = 0; m_head = (m_head + 1) % D; m_occ--; end
    if (afire) begin
      m_v[m_tail] = 1; m_i[m_tail] = 0; m_d[m_tail] = 0;
      m_kind[m_tail] = int'(alloc_kind);
      m_addr[m_tail] = int'(alloc_addr);
      m_k[m_tail] = alloc_addr_known || alloc_kind[1];
      m_tail = (m_tail + 1) % D; m_occ++;
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    mode = 2'(n_mode); alloc_valid = n_av; alloc_kind = 2'(n_ak); alloc_addr = 16'(n_aa);
    alloc_addr_known = n_kn; rslv_valid = n_rv; rslv_idx = 3'(n_ri); rslv_addr = 16'(n_ra);
    issue_ready = n_rdy; cmpl_valid = n_cv; cmpl_idx = 3'(n_ci);
    #1;
    compare_now();
    model_step();
    n_av = 0; n_rv = 0; n_cv = 0; n_rdy = 0;
  endtask

  task automatic put(input int kind, input int a, input bit known);
    n_av = 1; n_ak = kind; n_aa = a; n_kn = known;
    cyc();
  endtask

  task automatic drain();
    for (int c = 0; c < 200 && m_occ > 0; c++) begin
      n_rdy = 1;
      for (int k = 0; k < D; k++) begin
        int s;
        s = (m_head + k) % D;
        if (!n_cv && m_v[s] && m_i[s] && !m_d[s]) begin n_cv = 1; n_ci = s; end
        if (!n_rv && m_v[s] && !m_k[s] && m_kind[s] < 2) begin n_rv = 1; n_ri = s; n_ra = 9; end
      end
      cyc();
    end
  endtask

  task automatic run_mode(input int m);
    n_mode = m; phase = mode_tag(m);
    cyc();
    put(1, 1, 1); put(0, 2, 1); put(0, 1, 1); put(1, 3, 1); put(1, 1, 1); put(0, 3, 1);
    for (int c = 0; c < 6; c++) begin n_rdy = 1; cyc(); end
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < D; k++) begin
      m_v[k] = 0; m_i[k] = 0; m_d[k] = 0; m_k[k] = 0; m_kind[k] = 0; m_addr[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    phase = "R1";
    chk(alloc_ready == 1'b1, "R1", "alloc_ready", int'(alloc_ready), 1);
    chk(issue_valid == 1'b0, "R1", "issue_valid", int'(issue_valid), 0);
    chk(issue_permit == 8'h00, "R1", "issue_permit", int'(issue_permit), 0);
    cyc();

    // R2: fill past capacity while holding issue back, then drain (R10, R11)
    phase = "R2"; n_mode = 3;
    for (int k = 0; k < 10; k++) put(0, k, 1);
    chk(alloc_ready == 1'b0, "R2", "full alloc_ready", int'(alloc_ready), 0);
    phase = "R11";
    drain();

    run_mode(0);
    run_mode(1);
    run_mode(2);
    run_mode(3);

    // R7: unknown older write blocks, then aliasing after resolve (R12)
    phase = "R7"; n_mode = 3; cyc();
    put(1, 0, 0); put(0, 2, 1); put(1, 5, 1);
    for (int c = 0; c < 3; c++) begin n_rdy = 1; cyc(); end
    phase = "R12";
    n_rv = 1; n_ri = m_head; n_ra = 2; cyc();
    n_rv = 1; n_ri = (m_head + 1) % D; n_ra = 7; cyc();
    phase = "R7";
    for (int c = 0; c < 3; c++) begin n_rdy = 1; cyc(); end
    drain();

    // R8: barrier serialisation in the weakest mode
    phase = "R8"; n_mode = 3; cyc();
    put(0, 1, 1); put(1, 2, 1); put(2, 0, 0); put(0, 3, 1); put(1, 4, 1);
    for (int c = 0; c < 4; c++) begin n_rdy = 1; cyc(); end
    drain();

    // R10: completion pulses for empty and unissued slots are ignored
    phase = "R10"; n_mode = 0; cyc();
    put(0, 1, 1); put(0, 2, 1);
    n_cv = 1; n_ci = (m_head + 1) % D; cyc();
    n_cv = 1; n_ci = (m_head + 5) % D; cyc();
    cyc();
    drain();

    // random traffic across all inputs
    phase = "RND";
    for (int c = 0; c < 4000; c++) begin
      int r;
      if (m_occ == 0 && ($urandom % 40) == 0) n_mode = $urandom % 4;
      if (($urandom % 3) != 0) begin
        r = $urandom % 10;
        n_av = 1; n_ak = (r < 4) ? 0 : (r < 8 ? 1 : 2);
        n_aa = $urandom % 4; n_kn = ($urandom % 10) < 7;
      end
      if (($urandom % 6) == 0) begin n_rv = 1; n_ri = $urandom % D; n_ra = $urandom % 4; end
      n_rdy = ($urandom % 10) < 6;
      if (($urandom % 2) == 0) begin
        int s;
        s = $urandom % D;
        for (int k = 0; k < D; k++) begin
          int q;
          q = (s + k) % D;
          if (!n_cv && m_v[q] && m_i[q] && !m_d[q]) begin n_cv = 1; n_ci = q; end
        end
      end else if (($urandom % 8) == 0) begin
        n_cv = 1; n_ci = $urandom % D;
      end
      cyc();
    end
    drain();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule